// File: doc/BRIEF.md
# Frame-Sync Serial Converter Host

This block is the host side of a 16-bit serial link to an analog-to-digital converter. The converter starts each transfer on a short frame-sync pulse rather than on chip select alone. For each request from user logic the block pulls chip select low. It then generates a serial clock from the system clock and issues the frame-sync pulse. It shifts a 16-bit command out, most significant bit first, and at the same time shifts the 16-bit result in.

When the last bit has been transferred, the block releases chip select, or keeps it low if so configured. It then holds the frame open until two conditions are met: the converter has raised its end-of-conversion interrupt, and a programmable minimum spacing since the frame-sync edge has elapsed. A timeout ends the wait if the interrupt never arrives. User logic sees a start pulse, a busy level and a one-cycle done strobe. The done strobe comes with the captured word and an error flag.

Top module: `fs_adc_host`

## Requirements
- R1: After reset, chip select is high, frame sync and the serial clock are low, and busy and done are low.
- R2: Every frame produces exactly 16 serial clock falling edges while chip select is low.
- R3: The command word is presented on the serial data output bit 15 first. Each bit is valid at its falling edge, and the next bit is driven on the following rising edge.
- R4: The result word is assembled from the serial data input sampled at the 16 falling edges, most significant bit first, and is only sampled while chip select is low.
- R5: Frame sync rises at least one half serial-clock period after chip select goes low, and only while chip select is low.
- R6: Frame sync rises together with the first serial-clock rising edge. It stays high for exactly one serial-clock period, so that exactly one falling edge lies inside the pulse.
- R7: The serial-clock half period equals the requested divider value in system clocks, with a floor of MIN_HALF (4 system clocks, so a 40 ns period at 200 MHz). Smaller requests are raised to that floor.
- R8: With the hold option clear, chip select is high between frames. With the hold option set, chip select stays low between frames.
- R9: Done without error is reported only after a rising edge of the interrupt line seen since the frame-sync rise, and no sooner than the minimum-spacing count of system clocks after that rise.
- R10: If the interrupt has not been seen within the timeout count of clocks after chip select is released, done is reported with the error flag set. The error flag stays valid until the next start.
- R11: Busy rises the cycle after an accepted start and falls in the same cycle as the one-cycle done strobe.
- R12: A start pulse while busy is ignored: it does not change the command in flight and produces no extra frame or done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run a frame |
| cmdIn | input | 16 | Command word to send, sampled at start |
| halfDiv | input | DIV_W | Serial-clock half period in system clocks |
| csHold | input | 1 | 1: keep chip select low between frames |
| minSpacing | input | SPACE_W | Minimum clocks from frame-sync rise to done |
| irqTimeout | input | TO_W | Clocks to wait for the interrupt before giving up |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 16 | Captured result word, valid from done |
| timeoutErr | output | 1 | Set with done when the interrupt wait timed out |
| adcCsN | output | 1 | Converter chip select, active low |
| adcSclk | output | 1 | Generated serial clock |
| adcFs | output | 1 | Frame-sync pulse |
| adcSdi | output | 1 | Serial command data to converter |
| adcSdo | input | 1 | Serial result data from converter |
| adcInt | input | 1 | Converter end-of-conversion interrupt |

## Verification
The bench uses the default parameters: 16-bit words, an 8-bit divider field with a floor of 4, and 16-bit spacing and timeout counters. At run time it varies the divider over 4, 6 and 1. The value 1 makes the floor of R7 visible as a measured 40 ns period. It also swaps the relative sizes of the minimum spacing and the model's interrupt delay, so that each side of the R9 gate is the one that holds the frame open. A small timeout combined with a model whose interrupt is disabled drives the error path of R10. That path is followed by a normal frame, which shows the block recovers.

// File: rtl/fsadc_pkg.sv
`timescale 1ns/100ps
package fsadc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_XFER,
    ST_TRAIL,
    ST_GAP
  } ctlState_t;

  // Strobes from the sequencer to the datapath, all single-cycle.
  typedef struct packed {
    logic clearDiv;
    logic loadCmd;
    logic sclkSet;
    logic sclkClr;
    logic shiftOut;
    logic capture;
    logic latchResult;
  } dpStrobe_t;

endpackage

// File: rtl/fsadc_datapath.sv
`timescale 1ns/100ps
module fsadc_datapath
  import fsadc_pkg::*;
#(
  parameter int WORD_BITS = 16,
  parameter int DIV_W     = 8,
  parameter int MIN_HALF  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strb,
  input  logic [DIV_W-1:0]     halfDiv,
  input  logic [WORD_BITS-1:0] cmdIn,
  input  logic                 adcSdo,
  output logic                 tick,
  output logic                 adcSclk,
  output logic                 adcSdi,
  output logic [WORD_BITS-1:0] result
);

  localparam logic [DIV_W-1:0] MIN_HALF_V = DIV_W'(MIN_HALF);
  localparam logic [DIV_W-1:0] ONE_V      = DIV_W'(1);

  logic [DIV_W-1:0]     halfReg;
  logic [DIV_W-1:0]     halfCnt;
  logic [DIV_W-1:0]     halfSel;
  logic [WORD_BITS-1:0] txShift;
  logic [WORD_BITS-1:0] rxShift;

  // R7: requested half period, raised to the floor that keeps the
  // serial clock within the converter's rate limit.
  always_comb halfSel = (halfDiv < MIN_HALF_V) ? MIN_HALF_V : halfDiv;

  always_comb tick = (halfCnt == (halfReg - ONE_V)) && !strb.clearDiv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfReg <= MIN_HALF_V;
      halfCnt <= '0;
    end else begin
      if (strb.loadCmd) halfReg <= halfSel;
      if (strb.clearDiv || tick) halfCnt <= '0;
      else                       halfCnt <= halfCnt + ONE_V;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             adcSclk <= 1'b0;
    else if (strb.sclkSet) adcSclk <= 1'b1;
    else if (strb.sclkClr) adcSclk <= 1'b0;
  end

  // R3: command leaves MSB first, advancing on rising edges.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              txShift <= '0;
    else if (strb.loadCmd)  txShift <= cmdIn;
    else if (strb.shiftOut) txShift <= {txShift[WORD_BITS-2:0], 1'b0};
  end
  assign adcSdi = txShift[WORD_BITS-1];

  // R4: result enters MSB first on falling edges.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      result  <= '0;
    end else begin
      if (strb.capture)     rxShift <= {rxShift[WORD_BITS-2:0], adcSdo};
      if (strb.latchResult) result  <= rxShift;
    end
  end

  assert_half_floor_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sclkSet || strb.sclkClr) |-> (halfCnt + ONE_V >= MIN_HALF_V));

  assert_sclk_edge_on_tick_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sclkSet || strb.sclkClr) |-> tick);

  assert_no_set_clr_clash_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.sclkSet && strb.sclkClr));

endmodule

// File: rtl/fsadc_ctrl.sv
`timescale 1ns/100ps
module fsadc_ctrl
  import fsadc_pkg::*;
#(
  parameter int WORD_BITS = 16,
  parameter int SPACE_W   = 16,
  parameter int TO_W      = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               csHold,
  input  logic [SPACE_W-1:0] minSpacing,
  input  logic [TO_W-1:0]    irqTimeout,
  input  logic               tick,
  input  logic               adcInt,
  output dpStrobe_t          strb,
  output logic               busy,
  output logic               done,
  output logic               timeoutErr,
  output logic               adcCsN,
  output logic               adcFs
);

  localparam int HALVES = 2 * WORD_BITS;
  localparam int IDX_W  = $clog2(HALVES);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(HALVES - 1);
  localparam logic [IDX_W-1:0] IDX_FS   = IDX_W'(1);

  ctlState_t          state;
  logic [IDX_W-1:0]   halfIdx;
  logic [1:0]         intSync;
  logic               intPrev;
  logic               intRise;
  logic               intSeen;
  logic [SPACE_W-1:0] spaceCnt;
  logic               spaceOk;
  logic [TO_W-1:0]    toCnt;
  logic               timedOut;
  logic               gateOpen;
  logic               fsRise;

  always_comb begin
    intRise  = intSync[1] && !intPrev;
    spaceOk  = (spaceCnt >= minSpacing);
    timedOut = (toCnt >= irqTimeout);
    gateOpen = spaceOk && intSeen;
    fsRise   = (state == ST_LEAD) && tick;
    busy     = (state != ST_IDLE);
  end

  always_comb begin
    strb = '0;
    unique case (state)
      ST_IDLE: if (start) begin
        strb.clearDiv = 1'b1;
        strb.loadCmd  = 1'b1;
      end
      ST_LEAD: if (tick) strb.sclkSet = 1'b1;
      ST_XFER: if (tick) begin
        if (!halfIdx[0]) begin
          strb.sclkClr = 1'b1;
          strb.capture = 1'b1;
        end else if (halfIdx != IDX_LAST) begin
          strb.sclkSet  = 1'b1;
          strb.shiftOut = 1'b1;
        end
      end
      ST_TRAIL: ;
      ST_GAP: if (gateOpen || timedOut) strb.latchResult = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      adcCsN     <= 1'b1;
      adcFs      <= 1'b0;
      halfIdx    <= '0;
      intSync    <= '0;
      intPrev    <= 1'b0;
      intSeen    <= 1'b0;
      spaceCnt   <= '0;
      toCnt      <= '0;
      done       <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      intSync <= {intSync[0], adcInt};
      intPrev <= intSync[1];
      done    <= 1'b0;

      if (fsRise)       intSeen <= 1'b0;
      else if (intRise) intSeen <= 1'b1;

      if (fsRise)        spaceCnt <= '0;
      else if (!spaceOk) spaceCnt <= spaceCnt + SPACE_W'(1);

      unique case (state)
        ST_IDLE: begin
          adcCsN <= !csHold;
          if (start) begin
            adcCsN     <= 1'b0;
            timeoutErr <= 1'b0;
            state      <= ST_LEAD;
          end
        end
        ST_LEAD: if (tick) begin
          adcFs   <= 1'b1;
          halfIdx <= '0;
          state   <= ST_XFER;
        end
        ST_XFER: if (tick) begin
          halfIdx <= halfIdx + IDX_W'(1);
          if (halfIdx == IDX_FS)   adcFs <= 1'b0;
          if (halfIdx == IDX_LAST) state <= ST_TRAIL;
        end
        ST_TRAIL: if (tick) begin
          adcCsN <= !csHold;
          toCnt  <= '0;
          state  <= ST_GAP;
        end
        ST_GAP: begin
          if (!timedOut) toCnt <= toCnt + TO_W'(1);
          if (gateOpen || timedOut) begin
            done       <= 1'b1;
            timeoutErr <= !gateOpen;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_fs_after_cs_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcFs) |-> !$past(adcCsN));

  assert_fs_only_in_xfer_R6: assert property (@(posedge clk) disable iff (!rstN)
    adcFs |-> (state == ST_XFER));

  assert_capture_cs_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> !adcCsN);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_gate_before_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    (done && !timeoutErr) |-> (intSeen && spaceOk));

  assert_cs_hold_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_IDLE) && $past(state == ST_IDLE) && $past(csHold) && !$past(start)) |-> !adcCsN);

endmodule

// File: rtl/fs_adc_host.sv
`timescale 1ns/100ps
module fs_adc_host
  import fsadc_pkg::*;
#(
  parameter int WORD_BITS = 16,
  parameter int DIV_W     = 8,
  parameter int MIN_HALF  = 4,
  parameter int SPACE_W   = 16,
  parameter int TO_W      = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [WORD_BITS-1:0] cmdIn,
  input  logic [DIV_W-1:0]     halfDiv,
  input  logic                 csHold,
  input  logic [SPACE_W-1:0]   minSpacing,
  input  logic [TO_W-1:0]      irqTimeout,
  output logic                 busy,
  output logic                 done,
  output logic [WORD_BITS-1:0] result,
  output logic                 timeoutErr,
  output logic                 adcCsN,
  output logic                 adcSclk,
  output logic                 adcFs,
  output logic                 adcSdi,
  input  logic                 adcSdo,
  input  logic                 adcInt
);

  dpStrobe_t strb;
  logic      tick;

  fsadc_ctrl #(
    .WORD_BITS(WORD_BITS),
    .SPACE_W  (SPACE_W),
    .TO_W     (TO_W)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .csHold    (csHold),
    .minSpacing(minSpacing),
    .irqTimeout(irqTimeout),
    .tick      (tick),
    .adcInt    (adcInt),
    .strb      (strb),
    .busy      (busy),
    .done      (done),
    .timeoutErr(timeoutErr),
    .adcCsN    (adcCsN),
    .adcFs     (adcFs)
  );

  fsadc_datapath #(
    .WORD_BITS(WORD_BITS),
    .DIV_W    (DIV_W),
    .MIN_HALF (MIN_HALF)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .halfDiv(halfDiv),
    .cmdIn  (cmdIn),
    .adcSdo (adcSdo),
    .tick   (tick),
    .adcSclk(adcSclk),
    .adcSdi (adcSdi),
    .result (result)
  );

endmodule

// File: tb/tb_fs_adc_host.sv
`timescale 1ns/100ps
module tb_fs_adc_host;
  localparam int MIN_HALF = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] cmdIn = '0;
  logic [7:0]  halfDiv = 8'd4;
  logic        csHold = 1'b0;
  logic [15:0] minSpacing = 16'd20;
  logic [15:0] irqTimeout = 16'd2000;
  logic        busy, done, timeoutErr, adcCsN, adcSclk, adcFs, adcSdi;
  logic [15:0] result;
  logic        adcSdo = 1'b0;
  logic        adcInt = 1'b0;

  fs_adc_host dut (
    .clk(clk), .rstN(rstN), .start(start), .cmdIn(cmdIn), .halfDiv(halfDiv),
    .csHold(csHold), .minSpacing(minSpacing), .irqTimeout(irqTimeout),
    .busy(busy), .done(done), .result(result), .timeoutErr(timeoutErr),
    .adcCsN(adcCsN), .adcSclk(adcSclk), .adcFs(adcFs), .adcSdi(adcSdi),
    .adcSdo(adcSdo), .adcInt(adcInt)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] patFor(input int n);
    return 16'hC5A3 ^ (16'(n) * 16'h1357);
  endfunction

  typedef struct {
    logic [15:0] cmd;
    logic [15:0] res;
    bit          err;
    int          halfEff;
    int          minSp;
  } item_t;

  item_t q[$];
  int drvFrame = 0;
  int doneCnt = 0;

  // ---------------- converter model ----------------
  int       modelFrame = 0;
  realtime  csFallT = 0.0;
  realtime  fsRiseT = 0.0;
  realtime  lastFsT = 0.0;
  realtime  firstFallT = 0.0;
  int       periodNs = 0;
  int       fallCnt = 0;
  int       fsFalls = 0;
  int       curHalf = MIN_HALF;
  int       prevMinSp = 0;
  logic [15:0] rxWord = '0;
  logic [15:0] pat = '0;
  bit       intEnable = 1'b1;
  int       intDelayNs = 400;

  always @(negedge adcCsN) csFallT = $realtime;

  always @(posedge adcFs) begin
    chk(adcCsN == 1'b0, "R5", "chip select low at FS rise", adcCsN, 0);
    chk(($realtime - csFallT) >= curHalf * 5.0, "R5", "CS-to-FS ns",
        int'($realtime - csFallT), curHalf * 5);
    if (modelFrame > 0)
      chk(($realtime - lastFsT) >= prevMinSp * 5.0, "R9", "FS-to-FS ns",
          int'($realtime - lastFsT), prevMinSp * 5);
    prevMinSp = int'(minSpacing);
    lastFsT = $realtime;
    fsRiseT = $realtime;
    pat = patFor(modelFrame);
    modelFrame++;
    fallCnt = 0;
    fsFalls = 0;
    rxWord = '0;
    adcSdo = pat[15];
  end

  always @(posedge adcFs) begin
    adcInt = 1'b0;
    if (intEnable) begin
      #(intDelayNs);
      adcInt = 1'b1;
    end
  end

  always @(negedge adcFs) begin
    chk(int'($realtime - fsRiseT) == 2 * curHalf * 5, "R6", "FS width ns",
        int'($realtime - fsRiseT), 2 * curHalf * 5);
    chk(fsFalls == 1, "R6", "falling edges inside FS", fsFalls, 1);
  end

  always @(negedge adcSclk) begin
    if (!adcCsN) begin
      fallCnt++;
      rxWord = {rxWord[14:0], adcSdi};
      if (adcFs) fsFalls++;
      if (fallCnt == 1) firstFallT = $realtime;
      if (fallCnt == 2) periodNs = int'($realtime - firstFallT);
    end
  end

  always @(posedge adcSclk) begin
    if (fallCnt >= 1 && fallCnt < 16) adcSdo = pat[15 - fallCnt];
  end

  // ---------------- scoreboard monitor ----------------
  always @(negedge clk) begin
    if (rstN && done) begin
      doneCnt++;
      if (q.size() == 0) begin
        chk(1'b0, "R12", "done with no frame pending", 1, 0);
      end else begin
        item_t it;
        it = q.pop_front();
        chk(result == it.res, "R4", "result word", result, it.res);
        chk(timeoutErr == it.err, "R10", "timeout flag", timeoutErr, it.err);
        chk(fallCnt == 16, "R2", "falling edges per frame", fallCnt, 16);
        chk(rxWord == it.cmd, "R3", "command seen by converter", rxWord, it.cmd);
        chk(periodNs == 2 * it.halfEff * 5, "R7", "sclk period ns", periodNs, 2 * it.halfEff * 5);
        chk(busy == 1'b0, "R11", "busy low with done", busy, 0);
        if (!it.err) begin
          chk(adcInt == 1'b1, "R9", "interrupt high at done", adcInt, 1);
          chk(($realtime - lastFsT) >= it.minSp * 5.0, "R9", "FS-to-done ns",
              int'($realtime - lastFsT), it.minSp * 5);
        end
      end
    end
  end

  // ---------------- driver ----------------
  task automatic runFrame(input logic [15:0] cmd, input int half,
                          input bit expErr, input bit poke);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    halfDiv = 8'(half);
    it.cmd = cmd;
    it.res = patFor(drvFrame);
    drvFrame++;
    it.err = expErr;
    it.halfEff = (half < MIN_HALF) ? MIN_HALF : half;
    it.minSp = int'(minSpacing);
    curHalf = it.halfEff;
    q.push_back(it);
    cmdIn = cmd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R11", "busy after start", busy, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      cmdIn = ~cmd;
      start = 1'b1;  // R12: must be ignored
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(adcCsN == 1'b1, "R1", "reset chip select", adcCsN, 1);
    chk(adcFs == 1'b0, "R1", "reset FS", adcFs, 0);
    chk(adcSclk == 1'b0, "R1", "reset sclk", adcSclk, 0);
    chk(busy == 1'b0, "R1", "reset busy", busy, 0);
    chk(done == 1'b0, "R1", "reset done", done, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // interrupt delay dominates the gate
    minSpacing = 16'd20;
    intDelayNs = 400;
    runFrame(16'hA5F0, 4, 1'b0, 1'b0);
    chk(adcCsN == 1'b1, "R8", "toggle mode CS high between frames", adcCsN, 1);
    runFrame(16'h0001, 6, 1'b0, 1'b0);
    runFrame(16'h8000, 1, 1'b0, 1'b0);  // R7 floor

    // spacing dominates the gate
    minSpacing = 16'd300;
    intDelayNs = 100;
    runFrame(16'h1234, 4, 1'b0, 1'b0);

    // hold mode
    minSpacing = 16'd20;
    intDelayNs = 300;
    csHold = 1'b1;
    runFrame(16'hFFFF, 5, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk(adcCsN == 1'b0, "R8", "hold mode CS low between frames", adcCsN, 0);
    runFrame(16'h5A5A, 4, 1'b0, 1'b0);
    chk(adcCsN == 1'b0, "R8", "hold mode CS low after frame", adcCsN, 0);
    csHold = 1'b0;

    // R10 timeout, then recovery
    intEnable = 1'b0;
    irqTimeout = 16'd200;
    runFrame(16'h0F0F, 4, 1'b1, 1'b0);
    chk(timeoutErr == 1'b1, "R10", "error flag held after done", timeoutErr, 1);
    intEnable = 1'b1;
    irqTimeout = 16'd2000;
    runFrame(16'h7E81, 4, 1'b0, 1'b0);

    // R12 start while busy
    runFrame(16'h3C96, 4, 1'b0, 1'b1);
    repeat (400) @(negedge clk);
    chk(doneCnt == drvFrame, "R12", "done count", doneCnt, drvFrame);
    chk(modelFrame == drvFrame, "R12", "FS count", modelFrame, drvFrame);
    chk(q.size() == 0, "R12", "scoreboard drained", q.size(), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "R11", "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule